// File: doc/BRIEF.md
# Keyboard Controller Host Bus Interface

This block sits between an 8-bit host data bus and a keyboard scanning controller. The host selects the block with an active-low chip select. One address bit chooses between the data path (low) and the command/status path (high). Active-low read and write strobes set the direction of each transfer. A read of the data path returns the oldest key code from the key FIFO and removes it. A read of the status path returns a status byte built from the FIFO fill level, the FIFO full flag and the error latch. A write to the command path can clear the error latch.

The strobes are asynchronous to the block clock. They pass through a two-stage synchroniser. Each access takes effect once, on the trailing (rising) edge of its strobe, so one strobe gives exactly one FIFO pop or one command. The bus output is a combinational path with a separate output enable, so read data is valid while the strobe is still low. The block also drives an interrupt request line: high means a request is pending. The line drops for one cycle on every data read, then shows whether key data remains or an error is pending. The scanner and the FIFO storage are outside the block and are reached through plain ports.

Top module: `kbd_host_if`

## Requirements
- R1: `data_oe_o` is 1 only while `cs_ni`=0, `rd_ni`=0 and `wr_ni`=1. In every other case it is 0, and it is always 0 while `cs_ni`=1.
- R2: A read with `a0_i`=1 drives the status byte on `data_o`. The fields are: bit 7 = error latch, bit 5 = FIFO full, bits 3..0 = FIFO entry count. Bits 6 and 4 read as 0.
- R3: A read with `a0_i`=0 drives `fifo_head_i` on `data_o` when the count is non-zero, and 0x00 when the count is zero.
- R4: A data read with a non-empty FIFO gives one `fifo_pop_o` pulse, one cycle wide. The pulse is high in the cycle after the second clock edge that follows the rise of `rd_ni`.
- R5: A data read while the count is zero gives no pop.
- R6: Status reads, writes, and strobes made with `cs_ni`=1 give no pop.
- R7: `err_set_i` high at a clock edge sets `err_o` at that edge. `err_o` then holds until it is cleared. If a set and a clear come in the same cycle, the set wins.
- R8: A write of 0xC0 with `a0_i`=1 clears `err_o` at the third clock edge after the rise of `wr_ni`.
- R9: Other command codes, and 0xC0 written with `a0_i`=0, leave `err_o` unchanged.
- R10: `clr_i` high at a clock edge clears `err_o`.
- R11: After each data read, `irq_o` is 0 for the cycle after the third edge following the rise of `rd_ni`. From the next edge it equals (count ≠ 0) OR `err_o`.
- R12: While reset is held, `err_o`, `irq_o` and `fifo_pop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| a0_i | input | 1 | Path select: 1 = command/status, 0 = data |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| fifo_head_i | input | 8 | Oldest FIFO entry |
| fifo_count_i | input | CNT_W | FIFO entry count |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_pop_o | output | 1 | Remove the head entry, one-cycle pulse |
| err_set_i | input | 1 | Error event from the scanner |
| clr_i | input | 1 | External error clear, active high |
| err_o | output | 1 | Error latch |
| irq_o | output | 1 | Interrupt request, high = pending |

## Verification
Bus read data and the output enable are combinational. They are sampled one falling edge after the strobe falls, while the strobe is still low. Counted from the falling edge where the strobe rises:
- the pop pulse is due after two rising edges;
- the command clear is due after three rising edges;
- the interrupt drop is due after three rising edges;
- the recovered interrupt level is due after four rising edges.

`err_set_i` and `clr_i` act at the next rising edge. Every sample is taken on a falling edge, at exactly these counts, with the bench FIFO model updated on the rising edge where the pop is seen.

// File: rtl/kbd_host_pkg.sv
package kbd_host_pkg;
  localparam logic [7:0] CMD_CLR_ERR   = 8'hC0;
  localparam int         STAT_ERR_BIT  = 7;
  localparam int         STAT_FULL_BIT = 5;

  typedef enum logic [1:0] {
    ACT_RD_DATA = 2'd0,
    ACT_RD_STAT = 2'd1,
    ACT_WR_DATA = 2'd2,
    ACT_WR_CMD  = 2'd3
  } bus_act_e;
endpackage

// File: rtl/kbd_host_strobe.sv
module kbd_host_strobe
  import kbd_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              a0_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              act_valid_o,
  output bus_act_e          act_o,
  output logic [DATA_W-1:0] wdata_o
);
  typedef struct packed {
    logic              cs_n;
    logic              a0;
    logic              rd_n;
    logic              wr_n;
    logic [DATA_W-1:0] data;
  } bus_smp_t;

  localparam bus_smp_t IDLE = '{cs_n: 1'b1, a0: 1'b0, rd_n: 1'b1, wr_n: 1'b1, data: '0};

  bus_smp_t s1_q, s2_q, s3_q;

  // two sync stages plus one history stage for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= '{cs_n: cs_ni, a0: a0_i, rd_n: rd_ni, wr_n: wr_ni, data: data_i};
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  logic rd_rise, wr_rise;
  assign rd_rise = s2_q.rd_n & ~s3_q.rd_n;
  assign wr_rise = s2_q.wr_n & ~s3_q.wr_n;

  // qualifiers taken from s3, the last sample with the strobe still low
  always_comb begin
    act_valid_o = 1'b0;
    act_o       = ACT_RD_DATA;
    if (!s3_q.cs_n) begin
      if (rd_rise && s3_q.wr_n) begin
        act_valid_o = 1'b1;
        act_o       = s3_q.a0 ? ACT_RD_STAT : ACT_RD_DATA;
      end else if (wr_rise && s3_q.rd_n) begin
        act_valid_o = 1'b1;
        act_o       = s3_q.a0 ? ACT_WR_CMD : ACT_WR_DATA;
      end
    end
  end

  assign wdata_o = s3_q.data;

  assert_one_act_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |=> !act_valid_o);
endmodule

// File: rtl/kbd_host_status.sv
module kbd_host_status
  import kbd_host_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             full_i,
  input  logic             err_i,
  output logic [7:0]       status_o
);
  localparam int CNT_FIELD_W = 4;

  always_comb begin
    status_o                   = '0;
    status_o[CNT_FIELD_W-1:0]  = CNT_FIELD_W'(count_i);
    status_o[STAT_FULL_BIT]    = full_i;
    status_o[STAT_ERR_BIT]     = err_i;
  end

  initial begin
    if (CNT_W > CNT_FIELD_W) $display("kbd_host_status: CNT_W too wide for status field");
  end
endmodule

// File: rtl/kbd_host_err_irq.sv
module kbd_host_err_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_set_i,
  input  logic clr_pin_i,
  input  logic clr_cmd_i,
  input  logic data_rd_i,
  input  logic fifo_nz_i,
  output logic err_o,
  output logic irq_o
);
  logic err_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (err_set_i) begin
      err_q <= 1'b1;
    end else if (clr_pin_i || clr_cmd_i) begin
      err_q <= 1'b0;
    end
  end

  // request line drops one cycle per data read, then follows pending state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= data_rd_i ? 1'b0 : (fifo_nz_i | err_q);
  end

  assign err_o = err_q;
  assign irq_o = irq_q;

  assert_err_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> err_o);
  assert_err_cmd_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmd_i && !err_set_i) |=> !err_o);
  assert_err_pin_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pin_i && !err_set_i) |=> !err_o);
  assert_irq_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i |=> !irq_o);
endmodule

// File: rtl/kbd_host_if.sv
module kbd_host_if
  import kbd_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              a0_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] fifo_head_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic              fifo_full_i,
  output logic              fifo_pop_o,
  input  logic              err_set_i,
  input  logic              clr_i,
  output logic              err_o,
  output logic              irq_o
);
  logic              act_valid;
  bus_act_e          act;
  logic [DATA_W-1:0] wdata;
  logic [7:0]        status;
  logic              fifo_nz, data_rd, clr_cmd;

  kbd_host_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .a0_i       (a0_i),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .data_i     (data_i),
    .act_valid_o(act_valid),
    .act_o      (act),
    .wdata_o    (wdata)
  );

  kbd_host_status #(.CNT_W(CNT_W)) u_status (
    .count_i (fifo_count_i),
    .full_i  (fifo_full_i),
    .err_i   (err_o),
    .status_o(status)
  );

  assign fifo_nz = |fifo_count_i;
  assign data_rd = act_valid && (act == ACT_RD_DATA);
  assign clr_cmd = act_valid && (act == ACT_WR_CMD) && (wdata[7:0] == CMD_CLR_ERR);

  kbd_host_err_irq u_err_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_set_i(err_set_i),
    .clr_pin_i(clr_i),
    .clr_cmd_i(clr_cmd),
    .data_rd_i(data_rd),
    .fifo_nz_i(fifo_nz),
    .err_o    (err_o),
    .irq_o    (irq_o)
  );

  assign fifo_pop_o = data_rd & fifo_nz;

  // read path is combinational so data is valid while the strobe is low
  assign data_oe_o = ~cs_ni & ~rd_ni & wr_ni;
  always_comb begin
    if (a0_i)         data_o = DATA_W'(status);
    else if (fifo_nz) data_o = fifo_head_i;
    else              data_o = '0;
  end

  always_comb begin
    if (cs_ni) assert_bus_release_R1: assert (!data_oe_o);
  end

  assert_pop_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);
endmodule

// File: tb/kbd_host_if_bench.sv
module kbd_host_if_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       oe, pop, err_set = 1'b0, clr = 1'b0, err, irq;
  logic [3:0] count = '0;
  logic       full;
  logic [7:0] head;
  logic       load_en = 1'b0;
  logic [3:0] load_val = '0;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // FIFO model: head value tracks count, full at 8 entries
  assign head = 8'h50 + {4'h0, count};
  assign full = (count == 4'd8);
  always @(posedge clk) begin
    if (load_en)                    count <= load_val;
    else if (pop && count != 4'd0)  count <= count - 4'd1;
  end

  kbd_host_if u_kbd_host_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .a0_i(a0), .rd_ni(rd_n), .wr_ni(wr_n),
    .data_i(wdata), .data_o(rdata), .data_oe_o(oe), .fifo_head_i(head),
    .fifo_count_i(count), .fifo_full_i(full), .fifo_pop_o(pop),
    .err_set_i(err_set), .clr_i(clr), .err_o(err), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] v);
    @(negedge clk); load_en = 1'b1; load_val = v;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_set = 1'b1;
    @(negedge clk); err_set = 1'b0;
    check("R7 err set", err, 1);
  endtask

  task automatic bus_read(input logic a, input logic [7:0] exp, input logic exp_pop,
                          input logic exp_irq, input string req);
    @(negedge clk); cs_n = 1'b0; a0 = a; rd_n = 1'b0;
    @(negedge clk);
    check({req, " oe"}, oe, 1);
    check({req, " data"}, rdata, exp);
    @(negedge clk); @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check({req, " no early pop"}, pop, 0);
    @(negedge clk);
    check({req, " pop"}, pop, exp_pop);
    @(negedge clk);
    check({req, " pop width"}, pop, 0);
    if (!a) check("R11 irq drop", irq, 0);
    @(negedge clk);
    if (!a) check("R11 irq level", irq, exp_irq);
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; a0 = a; wr_n = 1'b0; wdata = d;
    @(negedge clk);
    check("R1 no drive on write", oe, 0);
    @(negedge clk); @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 no pop on write", pop, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12 err", err, 0);
    check("R12 irq", irq, 0);
    check("R12 pop", pop, 0);
    check("R1 oe idle", oe, 0);
  endtask

  task automatic t_deselected();
    load(4'd3);
    @(negedge clk); cs_n = 1'b1; a0 = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R1 oe with cs high", oe, 0);
    @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 no pop without cs", count, 3);
  endtask

  task automatic t_status();
    bus_read(1'b1, 8'h03, 1'b0, 1'b0, "R2 status count3");
    check("R6 status read keeps count", count, 3);
    load(4'd8);
    bus_read(1'b1, 8'h28, 1'b0, 1'b0, "R2 status full");
  endtask

  task automatic t_data_reads();
    load(4'd3);
    bus_read(1'b0, 8'h53, 1'b1, 1'b1, "R3 R4 head3");
    check("R4 one pop", count, 2);
    bus_read(1'b0, 8'h52, 1'b1, 1'b1, "R3 R4 head2");
    bus_read(1'b0, 8'h51, 1'b1, 1'b0, "R3 R4 last");
    check("R4 drained", count, 0);
    bus_read(1'b0, 8'h00, 1'b0, 1'b0, "R5 R3 empty");
    check("R5 count stays", count, 0);
  endtask

  task automatic t_errors();
    pulse_err();
    @(negedge clk);
    check("R11 irq on err", irq, 1);
    bus_read(1'b1, 8'h80, 1'b0, 1'b0, "R2 status err");
    bus_write(1'b1, 8'h40);
    check("R9 other cmd", err, 1);
    bus_write(1'b0, 8'hC0);
    check("R9 data path C0", err, 1);
    load(4'd1);
    bus_read(1'b0, 8'h51, 1'b1, 1'b1, "R11 err keeps irq");
    // clear command: err drops exactly at third edge after wr rise
    @(negedge clk); cs_n = 1'b0; a0 = 1'b1; wr_n = 1'b0; wdata = 8'hC0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 not yet", err, 1);
    @(negedge clk);
    check("R8 clear cmd", err, 0);
    pulse_err();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R10 clr pin", err, 0);
    // set wins over simultaneous clear
    @(negedge clk); clr = 1'b1; err_set = 1'b1;
    @(negedge clk); clr = 1'b0; err_set = 1'b0;
    check("R7 set wins", err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_deselected();
    t_status();
    t_data_reads();
    t_errors();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule